// File: doc/BRIEF.md
# Selectable Decade Prescaler and Source Selector

This block prepares the event stream for a downstream cycle counter. It takes a fast square wave and a slow square wave. Both arrive as digital levels that are already synchronized to the block clock. The fast wave either passes through unchanged or goes through a divide-by-ten stage. The divide-by-ten setting is meant for fast inputs above about 2 MHz. The fast-path result can then be inverted, so that the counter sees its more favourable edge when the input duty cycle is lopsided. Last, a select bit routes either the fast path or the slow wave to the output.

The three control bits come from CPU-written latches and are held as static levels. The block drives a registered square wave and a one-clock strobe that marks every rising edge of that wave. The downstream counter uses the strobe as its count enable. When the divide ratio bit changes, the decade counter returns to state zero, so no runt pulse is produced.

Top module: `evt_cond_top`

## Requirements
- R1: While `rst_n` is low, `sq_out` and `edge_stb` are 0 and the decade counter is at state 0.
- R2: With `div_en`=0, `inv_en`=0 and `src_slow`=0, `sq_out` equals the level of `fast_in` one clock earlier, and each fast rising edge yields exactly one strobe.
- R3: With `div_en`=1, starting from state 0, `sq_out` rises after the 5th fast rising edge and again after the 15th. This gives one strobe per ten fast rising edges, and none for fewer than five.
- R4: In divide-by-ten mode, `sq_out` is low for five fast input periods and then high for five.
- R5: The decade counter changes state only on a rising edge of the sampled `fast_in`, or when it is cleared.
- R6: Any change of `div_en` returns the decade counter to state 0. After a return to `div_en`=1, the output is low and needs five fresh rising edges to go high.
- R7: `inv_en`=1 inverts the fast path after the divider. Without division, strobes then mark fast falling edges. With division, they mark the wrap from state 9 to state 0 (the 10th rising edge).
- R8: `src_slow`=1 routes `slow_in` to `sq_out` without inversion. Activity on `fast_in` and the value of `inv_en` then have no effect on the output.
- R9: `edge_stb` is high for exactly one clock, in the first clock in which `sq_out` is 1 after having been 0.
- R10: `sq_out` is registered. It shows the selected, conditioned level one clock after that level appears at the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fast_in | input | 1 | Fast square wave, synchronized level |
| slow_in | input | 1 | Slow square wave, synchronized level |
| div_en | input | 1 | 1 = divide fast wave by ten, 0 = pass through |
| inv_en | input | 1 | 1 = invert fast path after the divider |
| src_slow | input | 1 | 1 = route slow wave, 0 = route fast path |
| sq_out | output | 1 | Conditioned square wave |
| edge_stb | output | 1 | One-clock pulse on each rising edge of `sq_out` |

## Verification
The fast wave is driven as bursts of whole periods in each combination of the three control bits, and the strobes are counted for each burst. Burst lengths of 4, 9, 10, 12 and 20 rising edges separate a correct divide-by-ten, with its phase set by the clear, from an off-by-one or an unreset counter. Inverted bursts show whether inversion sits before or after the divider, because the edge counts differ. Slow-source bursts, sent while the fast wave keeps toggling and inversion is on, show that the selector stands last and is not inverted. A ratio change in the middle of a cycle, a timed single edge and a count of high-time clocks check the clear, the strobe alignment and the duty cycle.

// File: rtl/evt_cond_pkg.sv
package evt_cond_pkg;
  localparam int unsigned DEF_DIV_RATIO = 10;

  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } src_sel_e;
endpackage

// File: rtl/evt_rise_det.sv
module evt_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic lvl_q,
  output logic rise
);
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_in;
    rise  = lvl_in & ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/evt_decade_div.sv
module evt_decade_div #(
  parameter int unsigned DIV_RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en,
  input  logic rise,
  output logic div_out
);
  localparam int unsigned CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV_RATIO / 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q;
  logic             mode_chg;
  logic             cnt_ce;

  always_comb begin
    mode_chg = (div_en != mode_q);
    cnt_ce   = mode_chg | (div_en & rise);
    cnt_d    = cnt_q;
    if (mode_chg)          cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
    div_out  = (cnt_q >= HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= div_en;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_clear_on_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en != mode_q) |=> (cnt_q == '0));
  assert_hold_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && (div_en == mode_q)) |=> $stable(cnt_q));
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (cnt_q == '0));
endmodule

// File: rtl/evt_path_sel.sv
module evt_path_sel
  import evt_cond_pkg::*;
(
  input  logic fast_lvl,
  input  logic div_lvl,
  input  logic slow_lvl,
  input  logic div_en,
  input  logic inv_en,
  input  logic src_slow,
  output logic sel_lvl
);
  logic     fast_path;
  logic     fast_pol;
  src_sel_e src;

  always_comb begin
    src       = src_sel_e'(src_slow);
    fast_path = div_en ? div_lvl : fast_lvl;
    fast_pol  = fast_path ^ inv_en;
    case (src)
      SRC_SLOW: sel_lvl = slow_lvl;
      default:  sel_lvl = fast_pol;
    endcase
  end
endmodule

// File: rtl/evt_strobe_out.sv
module evt_strobe_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_lvl,
  output logic sq_out,
  output logic edge_stb
);
  logic sq_d, stb_d;

  always_comb begin
    sq_d  = sel_lvl;
    stb_d = sel_lvl & ~sq_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_out   <= 1'b0;
      edge_stb <= 1'b0;
    end else begin
      sq_out   <= sq_d;
      edge_stb <= stb_d;
    end
  end

  assert_stb_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> (sq_out && !$past(sq_out)));
  assert_rise_has_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sq_out) |-> edge_stb);
  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> !edge_stb);
endmodule

// File: rtl/evt_cond_top.sv
module evt_cond_top
  import evt_cond_pkg::*;
#(
  parameter int unsigned DIV_RATIO = DEF_DIV_RATIO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_in,
  input  logic slow_in,
  input  logic div_en,
  input  logic inv_en,
  input  logic src_slow,
  output logic sq_out,
  output logic edge_stb
);
  logic fast_q, fast_rise, div_lvl, sel_lvl;

  evt_rise_det u_rise (
    .clk(clk), .rst_n(rst_n), .lvl_in(fast_in), .lvl_q(fast_q), .rise(fast_rise)
  );

  evt_decade_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .div_en(div_en), .rise(fast_rise), .div_out(div_lvl)
  );

  evt_path_sel u_sel (
    .fast_lvl(fast_in), .div_lvl(div_lvl), .slow_lvl(slow_in),
    .div_en(div_en), .inv_en(inv_en), .src_slow(src_slow), .sel_lvl(sel_lvl)
  );

  evt_strobe_out u_out (
    .clk(clk), .rst_n(rst_n), .sel_lvl(sel_lvl), .sq_out(sq_out), .edge_stb(edge_stb)
  );

  assert_slow_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_slow && $past(src_slow)) |-> (sq_out == $past(slow_in)));
  assert_pass_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(src_slow) && !$past(div_en) && !$past(inv_en)) |-> (sq_out == $past(fast_in)));
  assert_reset_out_R1: assert property (@(posedge clk)
    !rst_n |-> (!sq_out && !edge_stb));
endmodule

// File: tb/sim_evt_cond_top.sv
module sim_evt_cond_top;
  logic clk = 1'b0;
  logic rst_n, fast_in, slow_in, div_en, inv_en, src_slow;
  logic sq_out, edge_stb;
  int   total = 0, bad = 0;
  int   stb_cnt = 0;
  int   hi_cnt = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  evt_cond_top u0 (
    .clk(clk), .rst_n(rst_n), .fast_in(fast_in), .slow_in(slow_in),
    .div_en(div_en), .inv_en(inv_en), .src_slow(src_slow),
    .sq_out(sq_out), .edge_stb(edge_stb)
  );

  always @(negedge clk) begin
    if (edge_stb) stb_cnt++;
    if (sq_out)   hi_cnt++;
  end

  // columns: div, inv, src, fast periods, slow periods, expected strobes
  localparam int VEC[10][6] = '{
    '{0, 0, 0,  7, 3,  7},   // R2
    '{0, 1, 0,  6, 3,  6},   // R7
    '{1, 0, 0, 20, 3,  2},   // R3
    '{1, 0, 0, 12, 0,  1},   // R3
    '{1, 0, 0,  4, 0,  0},   // R3
    '{1, 1, 0, 10, 0,  1},   // R7
    '{1, 1, 0,  9, 0,  0},   // R7
    '{0, 0, 1,  8, 5,  5},   // R8
    '{1, 0, 1, 20, 4,  4},   // R8
    '{0, 1, 1,  5, 3,  3}    // R8
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fast_periods(input int n);
    for (int i = 0; i < n; i++) begin
      fast_in = 1'b1; clocks(2);
      fast_in = 1'b0; clocks(2);
    end
  endtask

  task automatic slow_periods(input int n);
    for (int i = 0; i < n; i++) begin
      slow_in = 1'b1; clocks(3);
      slow_in = 1'b0; clocks(3);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fast_in = 1'b1; slow_in = 1'b1;
    div_en = 1'b0; inv_en = 1'b0; src_slow = 1'b0;
    clocks(3);
    check("R1 sq_out in reset", int'(sq_out), 0);
    check("R1 edge_stb in reset", int'(edge_stb), 0);
    fast_in = 1'b0; slow_in = 1'b0;
    clocks(1);
    rst_n = 1'b1;
    clocks(3);
    check("R1 sq_out after release", int'(sq_out), 0);

    // table walk
    for (int r = 0; r < 10; r++) begin
      div_en = 1'b0; inv_en = 1'b0; src_slow = 1'b0;
      fast_in = 1'b0; slow_in = 1'b0;
      clocks(3);
      div_en = VEC[r][0][0]; inv_en = VEC[r][1][0]; src_slow = VEC[r][2][0];
      clocks(4);
      stb_cnt = 0;
      fork
        fast_periods(VEC[r][3]);
        slow_periods(VEC[r][4]);
      join
      clocks(4);
      check($sformatf("R2/R3/R7/R8 row %0d strobes", r), stb_cnt, VEC[r][5]);
    end

    // R10/R9: timing of a single pass-through edge
    div_en = 1'b0; inv_en = 1'b0; src_slow = 1'b0; fast_in = 1'b0;
    clocks(4);
    fast_in = 1'b1;
    clocks(1);
    check("R10 sq_out one clock after input", int'(sq_out), 1);
    check("R9 strobe with first high clock", int'(edge_stb), 1);
    clocks(1);
    check("R9 strobe lasts one clock", int'(edge_stb), 0);
    clocks(4);
    check("R9 no strobe while held high", int'(edge_stb), 0);
    fast_in = 1'b0;
    clocks(3);

    // R4: duty cycle over twenty fast periods
    div_en = 1'b1;
    clocks(4);
    hi_cnt = 0;
    fast_periods(20);
    clocks(2);
    check("R4 high clocks over two divided cycles", hi_cnt, 40);

    // R6/R5: ratio change mid-cycle clears the counter
    div_en = 1'b0; clocks(2);
    div_en = 1'b1; clocks(2);
    fast_periods(7);
    check("R3 divided output high after 7 edges", int'(sq_out), 1);
    div_en = 1'b0; clocks(1);
    div_en = 1'b1; clocks(4);
    check("R6 output low after ratio change", int'(sq_out), 0);
    stb_cnt = 0;
    clocks(10);
    check("R5 no advance without fast edges", int'(sq_out), 0);
    fast_periods(4);
    check("R6 no strobe for four fresh edges", stb_cnt, 0);
    fast_periods(1);
    clocks(2);
    check("R6 strobe on fifth fresh edge", stb_cnt, 1);

    // R8: fast activity ignored with slow source held low
    src_slow = 1'b1; inv_en = 1'b1; slow_in = 1'b0;
    clocks(3);
    stb_cnt = 0;
    fast_periods(15);
    check("R8 output held at slow level", int'(sq_out), 0);
    check("R8 no strobes from fast input", stb_cnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule